// File: doc/BRIEF.md
# Modem Status and Control Register Unit

This block holds the modem status register and the modem control register of a serial port. Four modem inputs (clear-to-send, data-set-ready, ring indicator and carrier detect) pass through a synchronizer. Their current levels sit in the upper nibble of the status register. The lower nibble collects change flags, and a status read clears them. The control register drives the request-to-send and data-terminal-ready pins. It also has a loop bit, which feeds the status levels from the control register in place of the pins.

A bus front end uses the block through a write strobe for the control register and a read strobe for the status register. An interrupt controller watches the change indication, which stays high while any change flag is set. Interrupt priority and the serial data path are handled outside this block.

Top module: `modem_status_unit`

## Requirements
- R1: After reset the status register reads 0xB0, meaning carrier detect, data-set-ready and clear-to-send are asserted and no change flag is set. The control register reads 0x08, with only the OUT2 bit (bit 3) set. Both output pins are low and the change indication is low.
- R2: Outside loopback, status bit 4 holds clear-to-send, bit 5 data-set-ready, bit 6 ring indicator and bit 7 carrier detect. Each bit shows its pin level SYNC_STAGES+1 clock edges after the pin changes.
- R3: A change in clear-to-send, data-set-ready or carrier detect sets status bit 0, bit 1 or bit 3 respectively. Each flag stays set until a status read clears it.
- R4: Status bit 2 is set only when the ring indicator level goes from 1 to 0. A rising ring indicator never sets it.
- R5: During a read strobe, the read data holds the status value from before the read. After that edge the low nibble is zero and the upper nibble is unchanged.
- R6: If a level change reaches the status register on the same edge that a read clears it, the flag for that change stays set.
- R7: A control write stores bits 4:0 of the write data and drops bits 7:5. The stored value appears on the control output after the edge.
- R8: A control write with bit 4 = 0 drives request-to-send from bit 1 and data-terminal-ready from bit 0. A write with bit 4 = 1 leaves both pins unchanged.
- R9: When control bit 4 is set, the status levels come from the control register: clear-to-send from bit 1, data-set-ready from bit 0, ring indicator from bit 2 and carrier detect from bit 3. The pins are ignored, and the change flags follow the same rules as in R3 and R4.
- R10: The change indication is high exactly when at least one of status bits 3:0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_q_o | output | 5 | Control register value |
| st_rd_i | input | 1 | Status register read strobe |
| st_q_o | output | 8 | Status register value (read data) |
| cts_i | input | 1 | Clear-to-send pin |
| dsr_i | input | 1 | Data-set-ready pin |
| ri_i | input | 1 | Ring indicator pin |
| dcd_i | input | 1 | Carrier detect pin |
| rts_o | output | 1 | Request-to-send pin |
| dtr_o | output | 1 | Data-terminal-ready pin |
| msc_irq_o | output | 1 | Modem status change indication |

## Verification
The bench builds the unit with SYNC_STAGES = 3 instead of the default of two. A pin edge therefore needs four edges to reach the status register. This opens a wide window for lining up a pin change with a read strobe, and it shows that the reference model follows the parameter rather than a fixed latency. Random pin toggles, reads and control writes, with loopback turned on and off, are mixed with directed sequences for the ring trailing edge, read-versus-change collisions and the pin-hold behaviour of writes that set the loop bit.

// File: rtl/msu_pkg.sv
package msu_pkg;
  localparam int NLINES = 4;
  localparam int CTLW   = 5;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;
  localparam logic [NLINES-1:0] LVL_RST = 4'b1011;
  localparam logic [CTLW-1:0]   CTL_RST = 5'b01000;
  localparam int CTL_LOOP = 4;
  localparam int CTL_RTS  = 1;
  localparam int CTL_DTR  = 0;

  function automatic logic [CTLW-1:0] keep_ctl(input logic [7:0] v);
    return v[CTLW-1:0];
  endfunction

  function automatic logic [NLINES-1:0] loop_levels(input logic [CTLW-1:0] c);
    logic [NLINES-1:0] l;
    l[IDX_CTS] = c[1];
    l[IDX_DSR] = c[0];
    l[IDX_RI]  = c[2];
    l[IDX_DCD] = c[3];
    return l;
  endfunction

  function automatic logic [NLINES-1:0] delta_of(input logic [NLINES-1:0] old_l,
                                                  input logic [NLINES-1:0] new_l);
    logic [NLINES-1:0] d;
    d = old_l ^ new_l;
    d[IDX_RI] = old_l[IDX_RI] & ~new_l[IDX_RI];
    return d;
  endfunction
endpackage

// File: rtl/msu_sync.sv
module msu_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d_i;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/msu_ctrl.sv
module msu_ctrl
  import msu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [7:0]      wdata_i,
  output logic [CTLW-1:0] ctl_q,
  output logic            rts_o,
  output logic            dtr_o
);
  logic [CTLW-1:0] wr_val;
  logic            pin_upd;

  assign wr_val  = keep_ctl(wdata_i);
  assign pin_upd = wr_i && !wr_val[CTL_LOOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
      rts_o <= 1'b0;
      dtr_o <= 1'b0;
    end else begin
      if (wr_i) ctl_q <= wr_val;
      if (pin_upd) begin
        rts_o <= wr_val[CTL_RTS];
        dtr_o <= wr_val[CTL_DTR];
      end
    end
  end

  p_pins_hold_loop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i[4]) |=> ($stable(rts_o) && $stable(dtr_o)));
  p_pins_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !wdata_i[4]) |=> (rts_o == ctl_q[CTL_RTS] && dtr_o == ctl_q[CTL_DTR]));
endmodule

// File: rtl/msu_status.sv
module msu_status
  import msu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] src_lvl,
  input  logic              rd_i,
  output logic [NLINES-1:0] level_q,
  output logic [NLINES-1:0] delta_q,
  output logic [NLINES-1:0] new_delta
);
  logic [NLINES-1:0] kept;

  assign new_delta = delta_of(level_q, src_lvl);
  assign kept      = rd_i ? '0 : delta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= LVL_RST;
      delta_q <= '0;
    end else begin
      level_q <= src_lvl;
      delta_q <= kept | new_delta;
    end
  end

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((delta_q & $past(delta_q)) == $past(delta_q)));
  p_change_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (((level_q ^ $past(level_q)) & 4'b1011) != 0) |-> (delta_q != 0));
  p_teri_trailing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta_q[IDX_RI]) |-> $fell(level_q[IDX_RI]));
  p_clear_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && new_delta == 0) |=> (delta_q == 0));
  p_survive_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && new_delta != 0) |=> (delta_q != 0));
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_wr_i,
  input  logic [7:0]      ctl_wdata_i,
  output logic [CTLW-1:0] ctl_q_o,
  input  logic            st_rd_i,
  output logic [7:0]      st_q_o,
  input  logic            cts_i,
  input  logic            dsr_i,
  input  logic            ri_i,
  input  logic            dcd_i,
  output logic            rts_o,
  output logic            dtr_o,
  output logic            msc_irq_o
);
  logic [NLINES-1:0] pins, pins_s, src_lvl, level_q, delta_q, new_delta;
  logic              loop_on;

  assign pins = {dcd_i, ri_i, dsr_i, cts_i};

  msu_sync #(.W(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(LVL_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins), .q_o(pins_s));

  msu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr_i), .wdata_i(ctl_wdata_i),
    .ctl_q(ctl_q_o), .rts_o(rts_o), .dtr_o(dtr_o));

  assign loop_on = ctl_q_o[CTL_LOOP];
  assign src_lvl = loop_on ? loop_levels(ctl_q_o) : pins_s;

  msu_status u_status (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .rd_i(st_rd_i),
    .level_q(level_q), .delta_q(delta_q), .new_delta(new_delta));

  assign st_q_o    = {level_q, delta_q};
  assign msc_irq_o = |delta_q;

  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msc_irq_o) |-> $past(new_delta) != 0);
  p_loop_levels_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_on && $stable(ctl_q_o)) |=> (level_q == loop_levels($past(ctl_q_o))));
endmodule

// File: tb/modem_status_unit_test.sv
module modem_status_unit_test;
  localparam int S = 3;

  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, st_rd = 0;
  logic [7:0] ctl_wdata = 0;
  logic cts = 1, dsr = 1, ri = 0, dcd = 1;
  logic [4:0] ctl_q;
  logic [7:0] st_q;
  logic rts, dtr, irq;

  int checks = 0, errors = 0, cyc = 0;

  // reference model state
  logic [3:0] m_pipe [S];
  logic [3:0] m_lvl, m_dl;
  logic [4:0] m_ctl;
  logic m_rts, m_dtr;

  always #2 clk = ~clk;

  modem_status_unit #(.SYNC_STAGES(S)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
    .ctl_q_o(ctl_q), .st_rd_i(st_rd), .st_q_o(st_q),
    .cts_i(cts), .dsr_i(dsr), .ri_i(ri), .dcd_i(dcd),
    .rts_o(rts), .dtr_o(dtr), .msc_irq_o(irq));

  function automatic logic [3:0] b_flags(input logic [3:0] o, input logic [3:0] n);
    logic [3:0] f;
    for (int i = 0; i < 4; i++) f[i] = (i == 2) ? (o[i] && !n[i]) : (o[i] != n[i]);
    return f;
  endfunction

  function automatic logic [3:0] b_loop(input logic [4:0] c);
    return {c[3], c[2], c[0], c[1]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < S; i++) m_pipe[i] = 4'b1011;
    m_lvl = 4'b1011; m_dl = 0; m_ctl = 5'b01000; m_rts = 0; m_dtr = 0;
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " status"}, st_q, {m_lvl, m_dl});
    chk("R7 control", ctl_q, m_ctl);
    chk("R8 rts", rts, m_rts);
    chk("R8 dtr", dtr, m_dtr);
    chk("R10 irq", irq, |m_dl);
  endtask

  // drive inputs at negedge, advance one edge, compare
  task automatic step(input string tag, input logic rd, input logic wr, input logic [7:0] wd,
                      input logic [3:0] p);
    logic [3:0] src, nlvl, ndl;
    @(negedge clk);
    st_rd = rd; ctl_wr = wr; ctl_wdata = wd;
    {dcd, ri, dsr, cts} = p;
    #0.5;
    if (rd) chk("R5 read data", st_q, {m_lvl, m_dl});
    src  = m_ctl[4] ? b_loop(m_ctl) : m_pipe[S-1];
    nlvl = src;
    ndl  = (rd ? 4'b0 : m_dl) | b_flags(m_lvl, src);
    @(posedge clk);
    #1;
    for (int i = S-1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
    m_pipe[0] = p;
    m_lvl = nlvl; m_dl = ndl;
    if (wr) begin
      m_ctl = wd[4:0];
      if (!wd[4]) begin m_rts = wd[1]; m_dtr = wd[0]; end
    end
    compare_all(tag);
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] p;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset status", st_q, 8'hB0);
    chk("R1 reset control", ctl_q, 5'h08);
    chk("R1 reset pins", {rts, dtr, irq}, 3'b000);
    @(negedge clk); rst_n = 1;
    p = 4'b1011;

    // R2 / R3: drop CTS, wait for latency
    p[0] = 0;
    for (int i = 0; i < S + 2; i++) step("R2 R3", 0, 0, 0, p);
    chk("R3 cts flag", {st_q[4], st_q[0]}, 2'b01);
    step("R5", 1, 0, 0, p);
    chk("R5 cleared", st_q, {4'b1010, 4'b0000});

    // R4: ring rise gives no flag, fall gives bit 2
    p[2] = 1;
    for (int i = 0; i < S + 2; i++) step("R4 rise", 0, 0, 0, p);
    chk("R4 rise no teri", st_q[2], 1'b0);
    p[2] = 0;
    for (int i = 0; i < S + 2; i++) step("R4 fall", 0, 0, 0, p);
    chk("R4 teri on fall", st_q[2], 1'b1);
    step("R5", 1, 0, 0, p);

    // R6: change reaches register on read edge
    p[1] = 0;
    for (int i = 0; i < S; i++) step("R6 prep", 0, 0, 0, p);
    step("R6 collide", 1, 0, 0, p);
    chk("R6 flag survives", st_q[1], 1'b1);
    step("R5", 1, 0, 0, p);

    // R7 / R8
    step("R7", 0, 1, 8'hE3, p);
    chk("R7 upper bits dropped", ctl_q, 5'h03);
    chk("R8 pins driven", {rts, dtr}, 2'b11);
    step("R8 loop write", 0, 1, 8'h10, p);
    chk("R8 pins held", {rts, dtr}, 2'b11);

    // R9: loopback with pins ignored
    step("R9", 0, 1, 8'h1E, ~p);
    step("R9", 0, 0, 0, p);
    chk("R9 loop levels", st_q[7:4], 4'b1101);
    step("R9", 1, 0, 0, 4'b0000);
    step("R9", 0, 1, 8'h10, 4'b1111);
    step("R9", 0, 0, 0, 4'b1111);
    chk("R9 loop ri fall", st_q[7:0] & 8'hF4, 8'h04);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic rd, wr;
      logic [7:0] wd;
      if ($urandom_range(0, 5) == 0) p[$urandom_range(0, 3)] ^= 1'b1;
      rd = ($urandom_range(0, 3) == 0);
      wr = ($urandom_range(0, 15) == 0);
      wd = 8'($urandom());
      step(m_ctl[4] ? "R9 rand" : "R2 R3 R4 R6 rand", rd, wr, wd, p);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule